// File: doc/BRIEF.md
# Six-Entry Dual-Clock FIFO

This block moves data words from one clock domain to another, unrelated one through a six-slot register array. The producer presents words with a valid/ready handshake on the write clock. The consumer takes them with a valid/ready handshake on the read clock. Each side also sees a plain full or empty flag and an early-warning flag.

Each side keeps a binary slot pointer that counts 0 to 5 and then returns to 0, together with a lap bit that toggles on each return. The pointer crosses to the other domain as a 4-bit word that changes in exactly one bit per step, including across the wrap. The word is built from the cyclic six-word code 001, 011, 010, 110, 111, 101 in the low three bits and the lap bit on top. On even laps slot p uses the p-th code word. On odd laps slot p uses word 5-p, so the step that toggles the lap bit leaves the low bits alone. The word is registered where it is produced and passes through a two-flop synchronizer on the far side. It is then decoded back to slot and lap before any occupancy arithmetic.

Back-pressure rules: a word transfers on a write-clock edge when `wr_valid` and `wr_ready` are both high. It leaves on a read-clock edge when `rd_valid` and `rd_ready` are both high. `wr_ready` depends only on write-domain state, and `rd_valid` and `rd_data` depend only on read-domain state and stored data. Both are therefore stable between their own clock edges.

Top module: `ring6_fifo`

## Requirements
- R1: The FIFO stores up to six words and delivers them in the order they were accepted. With no reads, the sixth accepted word sets `wr_full`.
- R2: The crossing word of each pointer has the lap bit in bit 3. In bits 2:0 it holds code 001, 011, 010, 110, 111, 101 for slots 0 to 5 on even laps, and the same list indexed by 5-slot on odd laps. Consecutive values differ in at most one bit, and bits 2:0 are never 000 or 100.
- R3: A word written on the write side is not visible on the read side on the same edge. `rd_valid` rises within four read-clock cycles of the accepting write edge.
- R4: `wr_full` is high exactly when the write slot equals the synchronized read slot and the lap bits differ.
- R5: `rd_empty` is high exactly when the read pointer and the synchronized write pointer match in slot and lap.
- R6: `wr_almost_full` is high when the write side sees five or more occupied slots.
- R7: `rd_almost_empty` is high when the read side sees one or fewer occupied slots.
- R8: A write attempt while `wr_full` is high is refused. The word is not stored and the write pointer does not move.
- R9: A read attempt while `rd_empty` is high is refused, and the read pointer does not move.
- R10: `wr_ready` is the inverse of `wr_full`, and `rd_valid` is the inverse of `rd_empty`.
- R11: After reset, `rd_empty`, `rd_almost_empty` and `wr_ready` are high, and `wr_full`, `wr_almost_full` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_data | input | DATA_W | Word offered by the producer |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_ready | output | 1 | FIFO can accept a word this cycle |
| wr_full | output | 1 | All six slots occupied, as seen by the write side |
| wr_almost_full | output | 1 | Five or more slots occupied, as seen by the write side |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_data | output | DATA_W | Oldest stored word |
| rd_valid | output | 1 | `rd_data` holds a stored word |
| rd_ready | input | 1 | Consumer takes `rd_data` this cycle |
| rd_empty | output | 1 | No slot occupied, as seen by the read side |
| rd_almost_empty | output | 1 | One or no slot occupied, as seen by the read side |

## Verification
The assertions assume that both resets are held until each clock has ticked. They also assume that a producer holding `wr_valid` against a low `wr_ready` or a consumer pulling on an empty FIFO is legal and must be refused. The bench drives the handshake inputs only on the falling edge of their own clock, so every request is seen against a settled `wr_ready` or `rd_valid`. It deliberately keeps requesting through full and empty periods. The random phases use different write and read probabilities so the occupancy swings to both ends and the pointers wrap through many laps.

// File: rtl/ring6_pkg.sv
package ring6_pkg;

  localparam int SLOTS  = 6;
  localparam int SLOT_W = 3;
  localparam int WORD_W = SLOT_W + 1;

  typedef struct packed {
    logic              lap;
    logic [SLOT_W-1:0] pos;
  } ptr_t;

  localparam logic [WORD_W-1:0] RESET_WORD = 4'b0001;

  // cyclic six-word single-step code, index -> code
  function automatic logic [SLOT_W-1:0] slot_code(input logic [SLOT_W-1:0] idx);
    logic [SLOT_W-1:0] c;
    case (idx)
      3'd0:    c = 3'b001;
      3'd1:    c = 3'b011;
      3'd2:    c = 3'b010;
      3'd3:    c = 3'b110;
      3'd4:    c = 3'b111;
      3'd5:    c = 3'b101;
      default: c = 3'b001;
    endcase
    return c;
  endfunction

  function automatic logic [SLOT_W-1:0] code_slot(input logic [SLOT_W-1:0] c);
    logic [SLOT_W-1:0] idx;
    case (c)
      3'b001:  idx = 3'd0;
      3'b011:  idx = 3'd1;
      3'b010:  idx = 3'd2;
      3'b110:  idx = 3'd3;
      3'b111:  idx = 3'd4;
      3'b101:  idx = 3'd5;
      default: idx = 3'd0;
    endcase
    return idx;
  endfunction

  // odd laps walk the code backwards so the lap toggle is the only change
  function automatic logic [WORD_W-1:0] encode(input ptr_t p);
    logic [SLOT_W-1:0] idx;
    idx = p.lap ? (3'(SLOTS - 1) - p.pos) : p.pos;
    return {p.lap, slot_code(idx)};
  endfunction

  function automatic ptr_t decode(input logic [WORD_W-1:0] w);
    ptr_t p;
    logic [SLOT_W-1:0] idx;
    idx   = code_slot(w[SLOT_W-1:0]);
    p.lap = w[WORD_W-1];
    p.pos = p.lap ? (3'(SLOTS - 1) - idx) : idx;
    return p;
  endfunction

  function automatic ptr_t advance(input ptr_t p);
    ptr_t n;
    if (p.pos == 3'(SLOTS - 1)) begin
      n.lap = ~p.lap;
      n.pos = '0;
    end else begin
      n.lap = p.lap;
      n.pos = p.pos + 3'd1;
    end
    return n;
  endfunction

  // slots occupied between a write pointer and a read pointer (0..6)
  function automatic logic [SLOT_W-1:0] occupancy(input ptr_t w, input ptr_t r);
    logic [SLOT_W:0] d;
    d = {1'b0, w.pos} - {1'b0, r.pos};
    if (w.lap != r.lap) d = d + 4'(SLOTS);
    return d[SLOT_W-1:0];
  endfunction

endpackage

// File: rtl/ring6_ptr.sv
module ring6_ptr
  import ring6_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output ptr_t              ptr,
  output logic [WORD_W-1:0] word
);

  ptr_t nxt;

  always_comb begin
    nxt = step ? advance(ptr) : ptr;
  end

  // the crossing word is a register of its own, never encoder output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      word <= RESET_WORD;
    end else begin
      ptr  <= nxt;
      word <= encode(nxt);
    end
  end

endmodule

// File: rtl/ring6_sync.sv
module ring6_sync #(
  parameter int              WIDTH  = 4,
  parameter int              STAGES = 2,
  parameter logic [WIDTH-1:0] INIT  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[0] <= INIT;
        else        stage[0] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= INIT;
        else        stage[i] <= stage[i-1];
      end
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/ring6_store.sv
module ring6_store
  import ring6_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [SLOT_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SLOT_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [SLOTS];

  always_ff @(posedge wr_clk) begin
    if (we && (waddr < 3'(SLOTS))) mem[waddr] <= wdata;
  end

  always_comb begin
    rdata = (raddr < 3'(SLOTS)) ? mem[raddr] : '0;
  end

endmodule

// File: rtl/ring6_fifo.sv
module ring6_fifo
  import ring6_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic              wr_full,
  output logic              wr_almost_full,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              rd_empty,
  output logic              rd_almost_empty
);

  ptr_t              wr_ptr, rd_ptr;
  ptr_t              rd_ptr_w, wr_ptr_r;
  logic [WORD_W-1:0] wr_word, rd_word;
  logic [WORD_W-1:0] wr_word_s, rd_word_s;
  logic [SLOT_W-1:0] wr_fill, rd_fill;
  logic              push, pop;

  // write domain
  assign push = wr_valid && !wr_full;

  ring6_ptr u_wptr (
    .clk   (wr_clk),
    .rst_n (wr_rst_n),
    .step  (push),
    .ptr   (wr_ptr),
    .word  (wr_word)
  );

  ring6_sync #(.WIDTH(WORD_W), .STAGES(SYNC_STAGES), .INIT(RESET_WORD)) u_r2w (
    .clk   (wr_clk),
    .rst_n (wr_rst_n),
    .d     (rd_word),
    .q     (rd_word_s)
  );

  always_comb begin
    rd_ptr_w       = decode(rd_word_s);
    wr_fill        = occupancy(wr_ptr, rd_ptr_w);
    wr_full        = (wr_fill == 3'(SLOTS));
    wr_almost_full = (wr_fill >= 3'(SLOTS - 1));
    wr_ready       = !wr_full;
  end

  // read domain
  assign pop = rd_ready && !rd_empty;

  ring6_ptr u_rptr (
    .clk   (rd_clk),
    .rst_n (rd_rst_n),
    .step  (pop),
    .ptr   (rd_ptr),
    .word  (rd_word)
  );

  ring6_sync #(.WIDTH(WORD_W), .STAGES(SYNC_STAGES), .INIT(RESET_WORD)) u_w2r (
    .clk   (rd_clk),
    .rst_n (rd_rst_n),
    .d     (wr_word),
    .q     (wr_word_s)
  );

  always_comb begin
    wr_ptr_r        = decode(wr_word_s);
    rd_fill         = occupancy(wr_ptr_r, rd_ptr);
    rd_empty        = (rd_fill == '0);
    rd_almost_empty = (rd_fill <= 3'd1);
    rd_valid        = !rd_empty;
  end

  ring6_store #(.DATA_W(DATA_W)) u_store (
    .wr_clk (wr_clk),
    .we     (push),
    .waddr  (wr_ptr.pos),
    .wdata  (wr_data),
    .raddr  (rd_ptr.pos),
    .rdata  (rd_data)
  );

endmodule

// File: rtl/ring6_fifo_chk.sv
module ring6_fifo_chk (
  input logic       wr_clk,
  input logic       wr_rst_n,
  input logic       rd_clk,
  input logic       rd_rst_n,
  input logic [3:0] wr_word,
  input logic [3:0] rd_word,
  input logic [3:0] wr_word_s,
  input logic       wr_full,
  input logic       wr_almost_full,
  input logic       rd_empty,
  input logic       rd_almost_empty
);

  // R2
  wr_one_bit_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wr_word ^ $past(wr_word)) <= 1);

  // R2
  rd_one_bit_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rd_word ^ $past(rd_word)) <= 1);

  // R2
  sync_word_legal_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (wr_word_s[2:0] != 3'b000) && (wr_word_s[2:0] != 3'b100));

  // R8
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_full |=> $stable(wr_word));

  // R9
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_empty |=> $stable(rd_word));

  // R6
  full_warns_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_full |-> wr_almost_full);

  // R7
  empty_warns_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_empty |-> rd_almost_empty);

endmodule

bind ring6_fifo ring6_fifo_chk u_chk (
  .wr_clk          (wr_clk),
  .wr_rst_n        (wr_rst_n),
  .rd_clk          (rd_clk),
  .rd_rst_n        (rd_rst_n),
  .wr_word         (wr_word),
  .rd_word         (rd_word),
  .wr_word_s       (wr_word_s),
  .wr_full         (wr_full),
  .wr_almost_full  (wr_almost_full),
  .rd_empty        (rd_empty),
  .rd_almost_empty (rd_almost_empty)
);

// File: tb/ring6_fifo_bench.sv
`timescale 1ns/100ps
module ring6_fifo_bench;

  localparam int DW = 8;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_valid = 1'b0, rd_ready = 1'b0;
  logic          wr_ready, wr_full, wr_almost_full;
  logic [DW-1:0] rd_data;
  logic          rd_valid, rd_empty, rd_almost_empty;

  always #2.0 wr_clk = ~wr_clk;   // 250 MHz
  always #3.5 rd_clk = ~rd_clk;

  ring6_fifo #(.DATA_W(DW)) u_ring6_fifo (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_full(wr_full), .wr_almost_full(wr_almost_full),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_empty(rd_empty), .rd_almost_empty(rd_almost_empty)
  );

  int unsigned   n_run = 0, n_fail = 0;
  logic [DW-1:0] model [$];
  logic [DW-1:0] next_val = 8'h40;
  bit            done = 1'b0;

  function automatic bit exp_full(int n);   return n == 6; endfunction
  function automatic bit exp_afull(int n);  return n >= 5; endfunction
  function automatic bit exp_empty(int n);  return n == 0; endfunction
  function automatic bit exp_aempty(int n); return n <= 1; endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_once(input logic [DW-1:0] d, output bit acc);
    @(negedge wr_clk);
    acc      = wr_ready;
    wr_valid = 1'b1;
    wr_data  = d;
    if (acc) model.push_back(d);
    @(negedge wr_clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop_once(input string req, output bit acc);
    logic [DW-1:0] e;
    @(negedge rd_clk);
    acc      = rd_valid;
    rd_ready = 1'b1;
    if (acc) begin
      e = model.pop_front();
      check(req, "read data", int'(rd_data), int'(e));
    end
    @(negedge rd_clk);
    rd_ready = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    repeat (8) @(negedge wr_clk);
  endtask

  task automatic check_settled(input string tag);
    int n;
    n = model.size();
    check("R4", {tag, " wr_full"}, int'(wr_full), int'(exp_full(n)));
    check("R6", {tag, " wr_almost_full"}, int'(wr_almost_full), int'(exp_afull(n)));
    check("R5", {tag, " rd_empty"}, int'(rd_empty), int'(exp_empty(n)));
    check("R7", {tag, " rd_almost_empty"}, int'(rd_almost_empty), int'(exp_aempty(n)));
    check("R10", {tag, " wr_ready"}, int'(wr_ready), int'(!exp_full(n)));
    check("R10", {tag, " rd_valid"}, int'(rd_valid), int'(!exp_empty(n)));
  endtask

  task automatic random_phase(input int cycles, input int wr_pct, input int rd_pct);
    fork
      begin
        for (int i = 0; i < cycles; i++) begin
          @(negedge wr_clk);
          wr_valid = (($urandom % 100) < wr_pct);
          wr_data  = next_val;
          if (wr_valid && wr_ready) begin
            model.push_back(next_val);
            next_val = next_val + 8'd1;
          end
        end
        @(negedge wr_clk);
        wr_valid = 1'b0;
      end
      begin
        for (int i = 0; i < cycles; i++) begin
          @(negedge rd_clk);
          rd_ready = (($urandom % 100) < rd_pct);
          if (rd_ready && rd_valid) check("R1", "random read data", int'(rd_data), int'(model.pop_front()));
        end
        @(negedge rd_clk);
        rd_ready = 1'b0;
      end
    join
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit acc;
    int cnt;
    void'($urandom(32'h0005eed6));

    repeat (4) @(negedge rd_clk);
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;
    repeat (2) @(negedge rd_clk);

    // R11 reset state
    check("R11", "rd_empty", int'(rd_empty), 1);
    check("R11", "rd_almost_empty", int'(rd_almost_empty), 1);
    check("R11", "rd_valid", int'(rd_valid), 0);
    check("R11", "wr_full", int'(wr_full), 0);
    check("R11", "wr_almost_full", int'(wr_almost_full), 0);
    check("R11", "wr_ready", int'(wr_ready), 1);

    // R3 visibility latency
    push_once(8'hA5, acc);
    check("R3", "accepted", int'(acc), 1);
    check("R3", "not visible on write edge", int'(rd_valid), 0);
    cnt = 0;
    while (!rd_valid && cnt < 10) begin
      @(negedge rd_clk);
      cnt++;
    end
    check("R3", "visible within 4 read cycles", int'(cnt <= 4), 1);
    pop_once("R3", acc);
    settle();

    // R1 / R6 / R4 fill with no reads
    for (int k = 0; k < 6; k++) begin
      push_once(8'h10 + 8'(k), acc);
      check("R1", "fill accepted", int'(acc), 1);
      check("R6", "almost full during fill", int'(wr_almost_full), int'(k >= 4));
      check("R4", "full during fill", int'(wr_full), int'(k == 5));
    end
    check("R10", "wr_ready low when full", int'(wr_ready), 0);

    // R8 push while full refused
    push_once(8'hEE, acc);
    check("R8", "push refused when full", int'(acc), 0);
    settle();
    check_settled("full");

    // R1 / R7 / R5 drain
    for (int k = 0; k < 6; k++) begin
      pop_once("R1", acc);
      check("R1", "drain accepted", int'(acc), 1);
      check("R7", "almost empty during drain", int'(rd_almost_empty), int'(k >= 4));
      check("R5", "empty during drain", int'(rd_empty), int'(k == 5));
    end

    // R9 pop while empty refused
    pop_once("R9", acc);
    check("R9", "pop refused when empty", int'(acc), 0);
    settle();
    check_settled("drained");

    // R8 / R9 the refused word never shows up, read pointer unmoved
    push_once(8'h5C, acc);
    settle();
    check("R9", "one entry after refused pop", int'(rd_almost_empty && !rd_empty), 1);
    pop_once("R8", acc);
    check("R8", "sentinel read back", int'(acc), 1);
    settle();
    check_settled("sentinel");

    // random phases, pointers wrap through many laps
    random_phase(3000, 70, 30);
    settle();
    check_settled("write-heavy");
    random_phase(3000, 30, 80);
    settle();
    check_settled("read-heavy");
    random_phase(4000, 50, 50);
    settle();
    check_settled("balanced");

    // R2 wrap across laps under sustained streaming
    random_phase(2000, 100, 100);
    settle();
    check_settled("streaming");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule